// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A four-wire style test interface (test clock, mode select, serial data in, serial data out) walks a 16-state controller. The controller chooses which internal register sits between the serial input and the serial output. The registers are a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification register and a boundary chain of configurable length. The boundary chain captures a parallel vector of pin values.

Test software first shifts in an instruction. The block decodes it and, for the two boundary instructions, asserts a signal that tells the functional core to release every output driver to high impedance. Data registers are then captured, shifted and updated through the usual capture, shift and update states. The serial output changes on the falling edge of the test clock and is marked valid only while a shift state is active.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: The serial output and its enable update on the falling edge of `tck`. `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR. While `tdo_oe` is 0, `tdo` reads 0.
- R2: Every scan register shifts toward bit 0. `tdi` enters the most significant bit, and `tdo` presents bit 0, so a register of length L returns the bits shifted in after L further shifts.
- R3: After `rst`, and whenever the controller is in Test-Logic-Reset, the active instruction is identification (code 001) and `core_hiz` is 0.
- R4: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state. From Shift-DR, four such edges are not enough.
- R5: Capture-IR loads the instruction shift register with binary 001 (bit 0 = 1, bit 1 = 0, upper bits 0). The first three bits shifted out of an instruction scan are therefore 1, 0, 0.
- R6: A shifted instruction becomes active only on the falling edge of `tck` in Update-IR. `core_hiz` keeps its previous value through Shift-IR and Exit1-IR.
- R7: Code 000 (external test) selects the boundary chain, captures `pin_vec` into it in Capture-DR, and drives `core_hiz` to 1.
- R8: Code 001 (identification) selects the 32-bit register, which captures `ID_CODE` in Capture-DR. `core_hiz` is 0, and bit 0 of the shifted-out value is 1.
- R9: Code 010 (sample with outputs off) selects the boundary chain, captures `pin_vec` in Capture-DR, and drives `core_hiz` to 1.
- R10: Code 111 and the reserved codes 011 through 110 select the 1-bit bypass stage. It captures 0, so the first bit of a data scan is 0 and each later output bit repeats the input one shift earlier. `core_hiz` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, forces Test-Logic-Reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| pin_vec | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` is driven (shift states) |
| core_hiz | output | 1 | Forces the functional output drivers to high impedance |

## Verification
The bench builds the block with a 12-bit boundary chain and an identification value other than the default. This lets a single 24-bit data scan first return the captured pins and then the bits that entered at the chain's top, which exercises the shift direction across the full length. A distinct identification value catches a register that is loaded from the wrong constant or shifted in the wrong order. The short chain keeps every scan to a few dozen clocks. Each instruction code is still reached, including two of the reserved ones, as well as a forced return to reset from deep inside the data column.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_BOUNDARY
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT   = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_RESET:  return m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_IDLE;
        endcase
    endfunction

    function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLEZ: return DR_BOUNDARY;
            OP_IDENT:              return DR_IDENT;
            default:               return DR_BYPASS;
        endcase
    endfunction

    function automatic logic decode_hiz(input logic [IR_W-1:0] op);
        return (op == OP_EXTEST) || (op == OP_SAMPLEZ);
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge tck) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    // R4
    five_ones_reset_chk: assert property (@(posedge tck) disable iff (rst)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_active
);

    always_ff @(posedge tck) begin
        if (rst)                    ir_shift <= '0;
        else if (state == ST_CAP_IR) ir_shift <= IR_CAPTURE;
        else if (state == ST_SH_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    always_ff @(negedge tck) begin
        if (rst || state == ST_RESET) ir_active <= OP_IDENT;
        else if (state == ST_UPD_IR)  ir_active <= ir_shift;
    end

    // R6
    ir_update_only_chk: assert property (@(posedge tck) disable iff (rst)
        !$stable(ir_active) |-> (state == ST_UPD_IR || state == ST_RESET));

    // R3
    reset_ident_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_RESET) |-> (ir_active == OP_IDENT));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 16,
    parameter logic [31:0] ID_CODE = 32'h0B3C_5069
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tdi,
    input  tap_state_e         state,
    input  dr_sel_e            sel,
    input  logic [BSR_LEN-1:0] pin_vec,
    output logic               dr_out
);

    localparam int ID_W = 32;

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= '0;
            bsr_q <= '0;
        end else if (state == ST_CAP_DR) begin
            case (sel)
                DR_BOUNDARY: bsr_q <= pin_vec;
                DR_IDENT:    id_q  <= ID_CODE;
                default:     byp_q <= 1'b0;
            endcase
        end else if (state == ST_SH_DR) begin
            case (sel)
                DR_BOUNDARY: bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
                DR_IDENT:    id_q  <= {tdi, id_q[ID_W-1:1]};
                default:     byp_q <= tdi;
            endcase
        end
    end

    always_comb begin
        case (sel)
            DR_BOUNDARY: dr_out = bsr_q[0];
            DR_IDENT:    dr_out = id_q[0];
            default:     dr_out = byp_q;
        endcase
    end

    // R10
    bypass_capture_chk: assert property (@(posedge tck) disable iff (rst)
        (state == ST_CAP_DR && sel == DR_BYPASS) |=> (byp_q == 1'b0));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
    import tap_pkg::*;
#(
    parameter int          BSR_LEN = 16,
    parameter logic [31:0] ID_CODE = 32'h0B3C_5069
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_vec,
    output logic               tdo,
    output logic               tdo_oe,
    output logic               core_hiz
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_active;
    dr_sel_e         dr_sel;
    logic            dr_out;
    logic            shift_bit;
    logic            in_shift;

    tap_fsm i_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state)
    );

    tap_ir i_ir (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (state),
        .ir_shift  (ir_shift),
        .ir_active (ir_active)
    );

    assign dr_sel   = decode_dr(ir_active);
    assign core_hiz = decode_hiz(ir_active);

    tap_dr #(
        .BSR_LEN (BSR_LEN),
        .ID_CODE (ID_CODE)
    ) i_dr (
        .tck     (tck),
        .rst     (rst),
        .tdi     (tdi),
        .state   (state),
        .sel     (dr_sel),
        .pin_vec (pin_vec),
        .dr_out  (dr_out)
    );

    assign in_shift  = (state == ST_SH_IR) || (state == ST_SH_DR);
    assign shift_bit = (state == ST_SH_IR) ? ir_shift[0] : dr_out;

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= in_shift ? shift_bit : 1'b0;
            tdo_oe <= in_shift;
        end
    end

    // R1
    oe_shift_chk: assert property (@(posedge tck) disable iff (rst)
        tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

    // R1
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (rst)
        !tdo_oe |-> (tdo == 1'b0));

endmodule

// File: tb/test_jtag_tap_ctrl.sv
`timescale 1ns/100ps
module test_jtag_tap_ctrl;

    localparam int          BSR_LEN = 12;
    localparam logic [31:0] ID_CODE = 32'h5A3C_96E1;

    logic               tck = 1'b0;
    logic               rst = 1'b1;
    logic               tms = 1'b1;
    logic               tdi = 1'b0;
    logic [BSR_LEN-1:0] pin_vec = '0;
    logic               tdo, tdo_oe, core_hiz;

    int n_chk  = 0;
    int n_fail = 0;

    jtag_tap_ctrl #(.BSR_LEN(BSR_LEN), .ID_CODE(ID_CODE)) i_jtag_tap_ctrl (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pin_vec(pin_vec),
        .tdo(tdo), .tdo_oe(tdo_oe), .core_hiz(core_hiz)
    );

    always #2 tck = ~tck;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // sample outputs left by the last falling edge, then drive the next rising edge
    task automatic tick(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck);
        #1;
        o   = tdo;
        oe  = tdo_oe;
        tms = m;
        tdi = d;
    endtask

    task automatic step(input logic m);
        logic o, oe;
        tick(m, 1'b0, o, oe);
    endtask

    task automatic shift_ir(input logic [2:0] op, output logic [2:0] cap,
                            output logic hiz_before, output logic oe_exit);
        logic o, oe;
        step(1); step(1); step(0); step(0);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, op[i], o, oe);
            cap[i] = o;
            check("R1 oe in Shift-IR", {63'd0, oe}, 64'd1);
        end
        tick(1'b1, 1'b0, o, oe);
        hiz_before = core_hiz;
        oe_exit    = oe;
        step(0);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, oe;
        dout = '0;
        step(1); step(0); step(0);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o, oe);
            dout[i] = o;
        end
        tick(1'b1, 1'b0, o, oe);
        check("R1 oe off in Exit1-DR", {63'd0, oe}, 64'd0);
        step(0);
    endtask

    task automatic load_op(input logic [2:0] op);
        logic [2:0] cap;
        logic hb, oex;
        shift_ir(op, cap, hb, oex);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        tms = 1'b1;
        repeat (3) @(negedge tck);
        #1 rst = 1'b0;
        check("R3 reset core_hiz", {63'd0, core_hiz}, 64'd0);
        check("R1 reset tdo_oe", {63'd0, tdo_oe}, 64'd0);
        check("R1 reset tdo", {63'd0, tdo}, 64'd0);
        step(0);
    endtask

    task automatic t_ident_default;
        logic [63:0] d;
        shift_dr(32, 64'd0, d);
        check("R3 R8 default ident scan", d[31:0], {32'd0, ID_CODE});
        check("R8 ident bit0 is one", {63'd0, d[0]}, 64'd1);
    endtask

    task automatic t_ir_capture_extest;
        logic [2:0] cap;
        logic hb, oex;
        logic [63:0] d;
        shift_ir(3'b000, cap, hb, oex);
        check("R5 capture-IR pattern", {61'd0, cap}, 64'd1);
        check("R6 hiz before Update-IR", {63'd0, hb}, 64'd0);
        check("R1 oe off in Exit1-IR", {63'd0, oex}, 64'd0);
        check("R7 extest hiz", {63'd0, core_hiz}, 64'd1);
        pin_vec = 12'hA5C;
        shift_dr(24, {40'd0, 12'd0, 12'h39B}, d);
        check("R7 extest pins captured", d[11:0], 64'hA5C);
        check("R2 msb in lsb out", d[23:12], 64'h39B);
    endtask

    task automatic t_samplez;
        logic [63:0] d;
        load_op(3'b010);
        check("R9 samplez hiz", {63'd0, core_hiz}, 64'd1);
        pin_vec = 12'h3C6;
        shift_dr(12, 64'd0, d);
        check("R9 samplez pins captured", d[11:0], 64'h3C6);
    endtask

    task automatic t_ident_op;
        logic [63:0] d;
        load_op(3'b001);
        check("R8 ident hiz", {63'd0, core_hiz}, 64'd0);
        shift_dr(32, 64'd0, d);
        check("R8 ident scan", d[31:0], {32'd0, ID_CODE});
    endtask

    task automatic t_bypass(input logic [2:0] op, input string tag);
        logic [63:0] d;
        load_op(op);
        check({tag, " bypass hiz"}, {63'd0, core_hiz}, 64'd0);
        shift_dr(8, 64'hB6, d);
        check({tag, " bypass delay"}, d[7:0], {56'd0, 8'h6C});
    endtask

    task automatic t_tms_reset;
        logic o, oe;
        load_op(3'b000);
        step(1); step(0); step(0);
        step(1); step(1); step(1); step(1);
        check("R4 four ones insufficient", {63'd0, core_hiz}, 64'd1);
        tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        check("R4 R3 five ones reach reset", {63'd0, core_hiz}, 64'd0);
        t_ident_default();
    endtask

    initial begin
        t_reset();
        t_ident_default();
        t_ir_capture_extest();
        t_samplez();
        t_ident_op();
        t_bypass(3'b111, "R10 code111");
        t_bypass(3'b011, "R10 code011");
        t_bypass(3'b110, "R10 code110");
        t_tms_reset();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL R4 watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule